// File: doc/BRIEF.md
# Reference Clock Prescaler and Divider

This block turns one of two reference clock streams into a divided output clock. Both references arrive as single-cycle enable pulses in the system clock domain. The block selects the internal or the external stream. It can pass the selected ticks through a fixed prescaler of 2 or 4, and then through an integer divider N. The result is a level output, `clk_out`, that runs as a clock. A full-bypass setting can skip the divider, and for the internal source it skips the prescaler as well. The output then carries one pulse per surviving tick.

Configuration comes from two 9-bit words. The mode word holds the source, the power-down enable, the prescaler, the bypass and the output-enable fields. The divide word holds the value of N. The words are captured only while reset is held. If `prog_mode` is high during that reset, the words are stored and the block stays silent in its programming state. A later reset with `prog_mode` low copies the stored words into the active setting, and the block runs from them. A select pin either chooses the source live or acts as a power-down input, depending on a configuration bit.

The controller has five states:
- `ST_BOOT` is entered on every reset. After one cycle it moves to `ST_PROG` if the reset was a programming reset. Otherwise it moves to `ST_FAULT` if the active mode word is invalid. Otherwise it moves to `ST_RUN` when the run condition holds, or to `ST_HALT` when it does not.
- `ST_PROG` and `ST_FAULT` are held until the next reset.
- `ST_HALT` moves to `ST_RUN` when the run condition becomes true.
- `ST_RUN` moves to `ST_HALT` when the run condition becomes false.

Top module: `refclk_divgen`

## Requirements
- R1: The words are stored on a clock edge that has `rst_n` low and `prog_mode` high, and the block then keeps `clk_out` low until the next reset. A reset with `prog_mode` low loads the stored words into the active setting. Changes on `mux_word` or `div_word` outside reset have no effect.
- R2: Mode word bits [8:6] are reserved. If any of them is 1 in the active word, `cfg_invalid` goes high one cycle after reset release and stays high, and `clk_out` stays low.
- R3: With the power-down enable (bit 1) at 1 and the pin high, the source bit (bit 0) picks the source: 1 for external, 0 for internal.
- R4: With bit 1 at 0, the source bit is ignored and `sel_pin` picks the source live: 1 for external, 0 for internal.
- R5: With bit 1 at 1 and `sel_pin` low, `clk_out` is low from the next cycle on and all counters clear. When the pin returns high, the first divided tick drives the output high again.
- R6: With output enable (bit 5) at 0, `clk_out` stays low.
- R7: With full bypass (bit 4) at 1 and the internal source selected, every internal tick gives a one-cycle high pulse on `clk_out` in the following cycle. Bits 2 and 3 have no effect.
- R8: With full bypass at 1 and the external source selected, the N divider is skipped but the prescaler still applies. `clk_out` pulses once per prescaled tick.
- R9: With bit 4 at 0 and prescaler bypass (bit 3) at 1, the prescaler is skipped and N still applies. The ratio bit has no effect.
- R10: With the prescaler active, ratio bit 2 at 0 divides by 4 and at 1 divides by 2.
- R11: N equals the divide word plus 2. Each output period covers N prescaled ticks. The output is high for ceil(N/2) of them and low for floor(N/2). Each new level appears in the cycle after the tick that causes it.
- R12: Right after reset release, `clk_out` and `cfg_invalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while it is low |
| prog_mode | input | 1 | High during reset to store the words, low to load the stored words |
| mux_word | input | 9 | Mode word: [0] source, [1] power-down enable, [2] ratio, [3] prescaler bypass, [4] full bypass, [5] output enable, [8:6] reserved |
| div_word | input | DIV_W (9) | Divider value; N is this value plus 2 |
| sel_pin | input | 1 | Live source select or power-down input |
| int_tick | input | 1 | Internal reference enable pulse |
| ext_tick | input | 1 | External reference enable pulse |
| clk_out | output | 1 | Divided output clock |
| cfg_invalid | output | 1 | The active mode word has a reserved bit set |

## Verification
The properties assume that the active configuration changes only while reset is low, and that a reset lasts long enough to see at least one clock edge. The stimulus respects both assumptions. Every reset is held for several edges, and all word changes made outside reset are meant to be ignored. The reference ticks and `sel_pin` are driven on the falling edge. Both edges then see the same stable values, including when the pin toggles while the divider is running.

// File: rtl/refclk_divgen_pkg.sv
package refclk_divgen_pkg;

    localparam int CFG_W    = 9;
    localparam int B_SRC    = 0;
    localparam int B_PDEN   = 1;
    localparam int B_RATIO  = 2;
    localparam int B_PRESK  = 3;
    localparam int B_FULLSK = 4;
    localparam int B_OUTEN  = 5;
    localparam int RSV_LO   = 6;
    localparam int RSV_HI   = 8;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_PROG,
        ST_FAULT,
        ST_HALT,
        ST_RUN
    } gen_state_e;

    typedef struct packed {
        logic src_ext;
        logic pd_en;
        logic ratio2;
        logic pre_skip;
        logic full_skip;
        logic out_en;
        logic bad;
    } mode_t;

    function automatic mode_t decode_mode(input logic [CFG_W-1:0] w);
        mode_t m;
        m.src_ext   = w[B_SRC];
        m.pd_en     = w[B_PDEN];
        m.ratio2    = w[B_RATIO];
        m.pre_skip  = w[B_PRESK];
        m.full_skip = w[B_FULLSK];
        m.out_en    = w[B_OUTEN];
        m.bad       = |w[RSV_HI:RSV_LO];
        return m;
    endfunction

endpackage

// File: rtl/refclk_src_sel.sv
module refclk_src_sel (
    input  logic src_ext,
    input  logic pd_en,
    input  logic pre_skip,
    input  logic full_skip,
    input  logic out_en,
    input  logic sel_pin,
    input  logic int_tick,
    input  logic ext_tick,
    output logic ref_tick,
    output logic run_ok,
    output logic pre_bypass
);

    logic use_ext;

    always_comb begin
        // pin is a live selector unless it has been given the power-down role
        use_ext    = pd_en ? src_ext : sel_pin;
        run_ok     = out_en && !(pd_en && !sel_pin);
        ref_tick   = use_ext ? ext_tick : int_tick;
        // full bypass drops the prescaler only on the internal source
        pre_bypass = pre_skip || (full_skip && !use_ext);
    end

endmodule

// File: rtl/refclk_prescale.sv
module refclk_prescale #(
    parameter int DIV_LONG  = 4,
    parameter int DIV_SHORT = 2
) (
    input  logic clk,
    input  logic clear,
    input  logic tick,
    input  logic bypass,
    input  logic ratio2,
    output logic fire
);

    localparam int CW = $clog2(DIV_LONG);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_comb begin
        lim  = ratio2 ? CW'(DIV_SHORT - 1) : CW'(DIV_LONG - 1);
        // >= keeps the count sane if the limit shrinks mid-run
        fire = tick && (bypass || (cnt >= lim));
    end

    always_ff @(posedge clk) begin
        if (clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= fire ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/refclk_ndiv.sv
module refclk_ndiv #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          clear,
    input  logic          tick,
    input  logic [DW-1:0] ratio_code,
    output logic          lvl
);

    localparam int CW = DW + 1;

    logic [CW-1:0] n_val;
    logic [CW-1:0] hi_len;
    logic [CW-1:0] pos;
    logic [CW-1:0] pos_nx;
    logic          started;

    always_comb begin
        n_val  = {1'b0, ratio_code} + CW'(2);
        hi_len = (n_val + CW'(1)) >> 1;
        if (!started || (pos == n_val - CW'(1))) begin
            pos_nx = '0;
        end else begin
            pos_nx = pos + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (clear) begin
            started <= 1'b0;
            pos     <= '0;
            lvl     <= 1'b0;
        end else if (tick) begin
            started <= 1'b1;
            pos     <= pos_nx;
            lvl     <= (pos_nx < hi_len);
        end
    end

endmodule

// File: rtl/refclk_divgen.sv
module refclk_divgen
    import refclk_divgen_pkg::*;
#(
    parameter int DIV_W     = 9,
    parameter int PRE_LONG  = 4,
    parameter int PRE_SHORT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_mode,
    input  logic [CFG_W-1:0] mux_word,
    input  logic [DIV_W-1:0] div_word,
    input  logic             sel_pin,
    input  logic             int_tick,
    input  logic             ext_tick,
    output logic             clk_out,
    output logic             cfg_invalid
);

    logic [CFG_W-1:0] stored_mux;
    logic [CFG_W-1:0] act_mux;
    logic [DIV_W-1:0] stored_div;
    logic [DIV_W-1:0] act_div;
    logic             prog_q;
    mode_t            mode;

    gen_state_e state_q;
    gen_state_e state_d;

    logic ref_tick;
    logic run_ok;
    logic pre_bypass;
    logic in_run;
    logic clear;
    logic run_tick;
    logic pre_tick;
    logic div_lvl;
    logic byp_q;

    // configuration is only captured while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_q <= prog_mode;
            if (prog_mode) begin
                stored_mux <= mux_word;
                stored_div <= div_word;
            end else begin
                act_mux <= stored_mux;
                act_div <= stored_div;
            end
        end
    end

    assign mode = decode_mode(act_mux);

    refclk_src_sel u_sel (
        .src_ext    (mode.src_ext),
        .pd_en      (mode.pd_en),
        .pre_skip   (mode.pre_skip),
        .full_skip  (mode.full_skip),
        .out_en     (mode.out_en),
        .sel_pin    (sel_pin),
        .int_tick   (int_tick),
        .ext_tick   (ext_tick),
        .ref_tick   (ref_tick),
        .run_ok     (run_ok),
        .pre_bypass (pre_bypass)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: begin
                if (prog_q) begin
                    state_d = ST_PROG;
                end else if (mode.bad) begin
                    state_d = ST_FAULT;
                end else if (run_ok) begin
                    state_d = ST_RUN;
                end else begin
                    state_d = ST_HALT;
                end
            end
            ST_PROG:  state_d = ST_PROG;
            ST_FAULT: state_d = ST_FAULT;
            ST_HALT:  state_d = run_ok ? ST_RUN : ST_HALT;
            ST_RUN:   state_d = run_ok ? ST_RUN : ST_HALT;
            default:  state_d = ST_BOOT;
        endcase
    end

    assign in_run   = (state_q == ST_RUN);
    assign clear    = !rst_n || !in_run;
    assign run_tick = ref_tick && in_run;

    refclk_prescale #(
        .DIV_LONG  (PRE_LONG),
        .DIV_SHORT (PRE_SHORT)
    ) u_pre (
        .clk    (clk),
        .clear  (clear),
        .tick   (run_tick),
        .bypass (pre_bypass),
        .ratio2 (mode.ratio2),
        .fire   (pre_tick)
    );

    refclk_ndiv #(
        .DW (DIV_W)
    ) u_div (
        .clk        (clk),
        .clear      (clear),
        .tick       (pre_tick),
        .ratio_code (act_div),
        .lvl        (div_lvl)
    );

    always_ff @(posedge clk) begin
        if (clear) begin
            byp_q <= 1'b0;
        end else begin
            byp_q <= pre_tick;
        end
    end

    // outputs
    always_comb begin
        clk_out     = 1'b0;
        cfg_invalid = 1'b0;
        unique case (state_q)
            ST_RUN:   clk_out = mode.full_skip ? byp_q : div_lvl;
            ST_FAULT: cfg_invalid = 1'b1;
            default: begin
                clk_out     = 1'b0;
                cfg_invalid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/refclk_divgen_chk.sv
module refclk_divgen_chk (
    input logic clk,
    input logic rst_n,
    input logic clk_out,
    input logic cfg_invalid,
    input logic sel_pin,
    input logic pd_en,
    input logic out_en,
    input logic full_skip,
    input logic in_run,
    input logic ref_tick,
    input logic pre_tick,
    input logic div_lvl
);

    p_fault_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_invalid |=> cfg_invalid);

    p_fault_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_invalid |-> !clk_out);

    p_pd_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_en && !sel_pin) |=> !clk_out);

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_run |=> !div_lvl);

    p_oe_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !clk_out);

    p_bypass_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && full_skip && pre_tick) |=> (clk_out || !in_run));

    p_tick_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pre_tick |-> ref_tick);

endmodule

bind refclk_divgen refclk_divgen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_out     (clk_out),
    .cfg_invalid (cfg_invalid),
    .sel_pin     (sel_pin),
    .pd_en       (mode.pd_en),
    .out_en      (mode.out_en),
    .full_skip   (mode.full_skip),
    .in_run      (in_run),
    .ref_tick    (ref_tick),
    .pre_tick    (pre_tick),
    .div_lvl     (div_lvl)
);

// File: tb/tb_refclk_divgen.sv
module tb_refclk_divgen;

    localparam int W_SRC  = 1;
    localparam int W_PDEN = 2;
    localparam int W_RAT  = 4;
    localparam int W_PSK  = 8;
    localparam int W_FSK  = 16;
    localparam int W_OE   = 32;
    localparam int W_RSV  = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_mode = 1'b1;
    logic [8:0] mux_word = '0;
    logic [8:0] div_word = '0;
    logic       sel_pin = 1'b1;
    logic       int_tick = 1'b0;
    logic       ext_tick = 1'b0;
    logic       clk_out;
    logic       cfg_invalid;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    bit    int_dense = 1;
    bit    cmp_on = 0;
    string cur_req = "R12";

    refclk_divgen dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_mode   (prog_mode),
        .mux_word    (mux_word),
        .div_word    (div_word),
        .sel_pin     (sel_pin),
        .int_tick    (int_tick),
        .ext_tick    (ext_tick),
        .clk_out     (clk_out),
        .cfg_invalid (cfg_invalid)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        int_tick <= int_dense ? 1'b1 : ($urandom % 3 == 0);
        ext_tick <= ($urandom % 2 == 0);
    end

    // behavioural reference model
    int   ms = 0;
    bit   mp = 0;
    int   sm = 0, sd = 0, am = 0, ad = 0;
    int   pc = 0, pos = 0;
    bit   started = 0, dl = 0, bq = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            if (prog_mode) begin
                sm = mux_word; sd = div_word;
            end else begin
                am = sm; ad = sd;
            end
            mp = prog_mode;
            ms = 0; pc = 0; pos = 0; started = 0; dl = 0; bq = 0;
        end else begin
            bit pdn, ue, rok, rt, fire;
            int p, n;
            pdn = am[1];
            ue  = pdn ? am[0] : sel_pin;
            rok = am[5] && !(pdn && !sel_pin);
            if (ms == 4) begin
                rt = ue ? ext_tick : int_tick;
                if (am[3] || (am[4] && !ue)) p = 1;
                else p = am[2] ? 2 : 4;
                fire = 0;
                if (rt) begin
                    pc = pc + 1;
                    if (pc >= p) begin pc = 0; fire = 1; end
                end
                bq = fire;
                if (fire) begin
                    n = ad + 2;
                    if (!started) begin started = 1; pos = 0; end
                    else pos = (pos + 1) % n;
                    dl = (pos < (n + 1) / 2);
                end
            end else begin
                pc = 0; pos = 0; started = 0; dl = 0; bq = 0;
            end
            case (ms)
                0: ms = mp ? 1 : ((am[8:6] != 0) ? 2 : (rok ? 4 : 3));
                1, 2: ms = ms;
                default: ms = rok ? 4 : 3;
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && cmp_on && !done) begin
            bit eo;
            eo = (ms == 4) ? (am[4] ? bq : dl) : 1'b0;
            chk(clk_out == eo, {cur_req, " clk_out"}, clk_out, eo);
            chk(cfg_invalid == (ms == 2), {cur_req, " cfg_invalid"}, cfg_invalid, ms == 2);
        end
    end

    task automatic do_reset(input bit prog, input logic [8:0] m, input logic [8:0] d);
        @(negedge clk);
        rst_n = 1'b0; prog_mode = prog; mux_word = m; div_word = d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // store words, then load them; words driven during the load reset are junk (R1)
    task automatic configure(input logic [8:0] m, input logic [8:0] d);
        do_reset(1'b1, m, d);
        @(negedge clk);
        do_reset(1'b0, ~m, ~d);
    endtask

    task automatic measure(output int per, output int hi);
        int  t = 0;
        bit  prev;
        per = -1; hi = -1;
        prev = clk_out;
        while (!(clk_out && !prev) && t < 3000) begin
            prev = clk_out; @(negedge clk); t++;
        end
        t = 0;
        while (clk_out && t < 3000) begin @(negedge clk); t++; end
        hi = t;
        while (!clk_out && t < 3000) begin @(negedge clk); t++; end
        per = t;
    endtask

    task automatic run_period(input string req, input int exp_per, input int exp_hi);
        int per, hi;
        repeat (30) @(negedge clk);
        measure(per, hi);
        chk(per == exp_per, {req, " period"}, per, exp_per);
        chk(hi == exp_hi, {req, " high time"}, hi, exp_hi);
    endtask

    initial begin
        int cnt;
        cmp_on = 1;
        // R1: programming reset leaves the output silent
        cur_req = "R1";
        do_reset(1'b1, 9'(W_OE | W_PDEN), 9'd1);
        chk(clk_out == 1'b0, "R12 out after reset", clk_out, 0);
        chk(cfg_invalid == 1'b0, "R12 invalid after reset", cfg_invalid, 0);
        cnt = 0;
        repeat (60) begin @(negedge clk); if (clk_out) cnt++; end
        chk(cnt == 0, "R1 silent in programming state", cnt, 0);

        // R10 R11 R3: internal, /4, N=3 -> 12 cycles, high 2 ticks of 4
        cur_req = "R10";
        do_reset(1'b0, 9'h1ff, 9'h1ff);
        chk(clk_out == 1'b0, "R12 out after load reset", clk_out, 0);
        run_period("R10 div4 N3", 12, 8);
        // R1: words changed while running are ignored
        mux_word = 9'(W_RAT | W_PSK); div_word = 9'd7;
        run_period("R1 live words ignored", 12, 8);

        cur_req = "R10";
        configure(9'(W_OE | W_PDEN | W_RAT), 9'd1);
        run_period("R10 div2 N3", 6, 4);

        cur_req = "R9";
        configure(9'(W_OE | W_PDEN | W_PSK), 9'd2);
        run_period("R9 prescaler skipped", 4, 2);
        configure(9'(W_OE | W_PDEN | W_PSK | W_RAT), 9'd2);
        run_period("R9 ratio ignored", 4, 2);

        cur_req = "R11";
        configure(9'(W_OE | W_PDEN | W_PSK), 9'd4);
        run_period("R11 even N6", 6, 3);
        configure(9'(W_OE | W_PDEN | W_PSK), 9'd5);
        run_period("R11 odd N7", 7, 4);
        configure(9'(W_OE | W_PDEN | W_PSK), 9'd0);
        run_period("R11 N2", 2, 1);

        // R3: source bit selects external with random ticks
        cur_req = "R3";
        int_dense = 0;
        configure(9'(W_OE | W_PDEN | W_SRC | W_RAT), 9'd1);
        repeat (400) @(negedge clk);

        // R7: full bypass on internal, prescaler controls ignored
        cur_req = "R7";
        configure(9'(W_OE | W_PDEN | W_FSK | W_RAT), 9'd9);
        repeat (400) @(negedge clk);

        // R8: full bypass on external keeps the prescaler
        cur_req = "R8";
        configure(9'(W_OE | W_PDEN | W_FSK | W_SRC | W_RAT), 9'd9);
        repeat (400) @(negedge clk);
        configure(9'(W_OE | W_PDEN | W_FSK | W_SRC), 9'd3);
        repeat (400) @(negedge clk);

        // R4: pin selects source live, source bit ignored
        cur_req = "R4";
        configure(9'(W_OE | W_SRC), 9'd0);
        for (int i = 0; i < 12; i++) begin
            sel_pin = i[0];
            repeat (37) @(negedge clk);
        end
        sel_pin = 1'b1;

        // R5: pin as power-down
        cur_req = "R5";
        int_dense = 1;
        configure(9'(W_OE | W_PDEN | W_PSK), 9'd2);
        repeat (20) @(negedge clk);
        sel_pin = 1'b0;
        @(negedge clk);
        cnt = 0;
        repeat (50) begin @(negedge clk); if (clk_out) cnt++; end
        chk(cnt == 0, "R5 output low in power-down", cnt, 0);
        sel_pin = 1'b1;
        repeat (2) @(negedge clk);
        chk(clk_out == 1'b1, "R5 restart high", clk_out, 1);
        run_period("R5 period after release", 4, 2);

        // R6: output enable off
        cur_req = "R6";
        configure(9'(W_PDEN | W_PSK), 9'd2);
        cnt = 0;
        repeat (60) begin @(negedge clk); if (clk_out) cnt++; end
        chk(cnt == 0, "R6 output disabled", cnt, 0);

        // R2: reserved bit set
        cur_req = "R2";
        configure(9'(W_OE | W_PDEN | W_RSV), 9'd0);
        repeat (2) @(negedge clk);
        chk(cfg_invalid == 1'b1, "R2 invalid flag", cfg_invalid, 1);
        cnt = 0;
        repeat (60) begin @(negedge clk); if (clk_out) cnt++; end
        chk(cnt == 0, "R2 output quiet", cnt, 0);
        configure(9'(W_OE | W_PDEN | 9'h100), 9'd0);
        repeat (3) @(negedge clk);
        chk(cfg_invalid == 1'b1, "R2 top reserved bit", cfg_invalid, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule